// File: doc/BRIEF.md
# Configuration-Over-Link Programming Sequencer

This block is the host-side master that loads a core configuration image into a target's configuration controller through a small register window. It drives a register read/write master port. Through that port it programs a mode register, a programming-control register and a data register, and it polls a status register. The full handshake has three parts. Setup enables the clock and the mode, waits out a settling delay made of dummy data writes, and asks the target to get ready. Transfer streams the image words while it watches for a configuration error. Teardown waits out a second dummy-write delay, releases control and waits until the target reports that its fabric clock and user mode are live.

The image arrives on a valid/ready stream of 32-bit words, with a last flag on the final word. A 2-bit image-type code is sampled when `start` is accepted: 0 plain, 1 encrypted, 2 compressed, 3 compressed and encrypted. The type decides how many target clocks each data write is given. When the run ends, `done` rises and holds. A 3-bit result code tells a clean load apart from the different failures, and `error` flags every non-zero result.

Register window, with the index on the low address bits:
- 0 is status. Bit 0 means enabled, bit 1 config-ready, bit 2 live config error, bit 3 fabric clock in use, bit 4 user mode, bit 5 latched error.
- 1 is mode. Bit 0 is the mode bit, bit 1 is clock-select, and bits 15:8 hold the clocks-per-write count.
- 2 is programming control. Bit 0 is configure and bit 1 is start-transfer.
- 3 is data.

Top module: `cfglink_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, `bus_req` and `img_ready` are 0 and `status_code` is 0.
- R2: Once `bus_req` is raised, it stays high with stable `bus_we`, `bus_addr` and `bus_wdata` until a cycle in which `bus_ack` is high. That cycle completes the access.
- R3: After `start`, the first accesses are status reads that repeat until bit 0 reads 1. If `POLL_LIMIT` reads in a row all see 0, the run ends with code 1 and makes no further access.
- R4: Setup then writes mode = 0x2, then mode = 0x3, then mode = 0x103. It then makes `DUMMY_WRITES` data writes of 0, and then writes control = 0x1.
- R5: Status is then polled until bit 1 reads 1. If `POLL_LIMIT` reads all fail, the run ends with code 2.
- R6: Next come mode = 0x103, `DUMMY_WRITES` data writes of 0, control = 0x3, and then mode = (clocks-per-write << 8) | 0x3. The clocks-per-write value is 1 for type 0, 4 for type 1, and 8 for types 2 and 3.
- R7: Each accepted word is written to the data register and followed by one status read. `img_ready` is high only while no bus access is pending. The word that carries `img_last` ends the transfer.
- R8: If the status read after a word shows bit 2 set, the transfer stops and no further word is taken. Teardown runs, and the final code is 3.
- R9: Teardown writes mode = 0x103, makes `DUMMY_WRITES` data writes of 0, writes control = 0x1 and then control = 0x0. It then polls status until bit 1 reads 0. A timeout gives code 4.
- R10: One further status read checks bit 5. If that bit is set and no transfer error was seen, the final code is 5.
- R11: Teardown then writes mode = 0x100 and polls until bits 3 and 4 both read 1. A timeout gives code 6. A clean run ends with code 0.
- R12: At the end, `busy` is 0, while `done`, `error` and `status_code` hold until the next accepted `start`. `error` is 1 exactly when the code is non-zero. A `start` pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (ignored while busy) |
| img_type | input | 2 | Image type, sampled with start |
| img_valid | input | 1 | Image word valid |
| img_ready | output | 1 | Image word accepted when high with valid |
| img_data | input | 32 | Image word |
| img_last | input | 1 | Marks the final image word |
| bus_req | output | 1 | Register access request |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Access completes in this cycle |
| bus_rdata | input | 32 | Read data, valid with ack |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished, held |
| error | output | 1 | Finished with a non-zero code |
| status_code | output | 3 | Result code |

## Verification
The assertions assume that the target raises `bus_ack` only while `bus_req` is high. They also assume that read data matters only in the acknowledged cycle. The bench's register model keeps to this by acknowledging a pending request after a random wait of zero to two cycles, and by dropping `bus_ack` on the following cycle. The image source holds each word and its last flag steady while valid is high, inserts random idle gaps, and never withdraws a word it has offered. Status bits change only in response to the sequencer's own writes and reads, so every poll sees a consistent target.

// File: rtl/cfglink_pkg.sv
package cfglink_pkg;

    localparam int WORD_W = 32;

    // status register bit positions
    localparam int SB_EN    = 0;
    localparam int SB_RDY   = 1;
    localparam int SB_ERR   = 2;
    localparam int SB_FCLK  = 3;
    localparam int SB_USER  = 4;
    localparam int SB_LATCH = 5;
    localparam int SB_TOP   = 5;

    // register indices
    localparam logic [1:0] RI_STAT = 2'd0;
    localparam logic [1:0] RI_MODE = 2'd1;
    localparam logic [1:0] RI_PCTL = 2'd2;
    localparam logic [1:0] RI_DATA = 2'd3;

    localparam logic [7:0] CPW_BASE = 8'h01;

    typedef enum logic [4:0] {
        ST_IDLE, ST_WEN, ST_CLK, ST_MODE, ST_CPW1, ST_DUM1, ST_CFG, ST_WRDY,
        ST_CPW2, ST_DUM2, ST_XST, ST_CPWT, ST_GET, ST_WR, ST_CHK,
        ST_TDCPW, ST_TDDUM, ST_TDXS, ST_TDCFG, ST_WNRDY, ST_LAT, ST_CLRM,
        ST_WUSR, ST_FIN
    } st_e;

    typedef enum logic [2:0] {
        CODE_OK       = 3'd0,
        CODE_TO_EN    = 3'd1,
        CODE_TO_RDY   = 3'd2,
        CODE_XFER_ERR = 3'd3,
        CODE_TO_NRDY  = 3'd4,
        CODE_LATCHED  = 3'd5,
        CODE_TO_USER  = 3'd6
    } code_e;

    typedef enum logic [1:0] {
        IMG_PLAIN   = 2'd0,
        IMG_ENC     = 2'd1,
        IMG_CMP     = 2'd2,
        IMG_CMP_ENC = 2'd3
    } img_e;

    typedef struct packed {
        logic              act;
        logic              we;
        logic [1:0]        idx;
        logic [WORD_W-1:0] data;
    } op_t;

    function automatic logic [7:0] cpw_for(img_e t);
        case (t)
            IMG_PLAIN: return 8'h01;
            IMG_ENC:   return 8'h04;
            default:   return 8'h08;
        endcase
    endfunction

    function automatic logic [WORD_W-1:0] mode_word(logic md, logic cs, logic [7:0] cpw);
        return {16'h0000, cpw, 6'b000000, cs, md};
    endfunction

endpackage

// File: rtl/cfglink_cnt.sv
module cfglink_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] val,
    output logic         last
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (load) cnt_q <= val;
        else if (dec)  cnt_q <= cnt_q - 1'b1;
    end

    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/cfglink_opgen.sv
module cfglink_opgen
    import cfglink_pkg::*;
(
    input  st_e               st,
    input  img_e              ty,
    input  logic [WORD_W-1:0] word,
    output op_t               op
);
    always_comb begin
        op      = '0;
        op.act  = 1'b1;
        op.we   = 1'b1;
        op.idx  = RI_MODE;
        op.data = '0;
        case (st)
            ST_WEN, ST_WRDY, ST_CHK, ST_WNRDY, ST_LAT, ST_WUSR: begin
                op.we  = 1'b0;
                op.idx = RI_STAT;
            end
            ST_CLK:                   op.data = mode_word(1'b0, 1'b1, 8'h00);
            ST_MODE:                  op.data = mode_word(1'b1, 1'b1, 8'h00);
            ST_CPW1, ST_CPW2, ST_TDCPW: op.data = mode_word(1'b1, 1'b1, CPW_BASE);
            ST_CPWT:                  op.data = mode_word(1'b1, 1'b1, cpw_for(ty));
            ST_CLRM:                  op.data = mode_word(1'b0, 1'b0, CPW_BASE);
            ST_DUM1, ST_DUM2, ST_TDDUM: op.idx = RI_DATA;
            ST_WR: begin
                op.idx  = RI_DATA;
                op.data = word;
            end
            ST_CFG, ST_TDXS: begin
                op.idx  = RI_PCTL;
                op.data = WORD_W'(1);
            end
            ST_XST: begin
                op.idx  = RI_PCTL;
                op.data = WORD_W'(3);
            end
            ST_TDCFG: op.idx = RI_PCTL;
            default:  op = '0;
        endcase
    end
endmodule

// File: rtl/cfglink_seq.sv
module cfglink_seq
    import cfglink_pkg::*;
#(
    parameter int ADDR_W       = 4,
    parameter int DUMMY_WRITES = 244,
    parameter int POLL_LIMIT   = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [1:0]        img_type,
    input  logic              img_valid,
    output logic              img_ready,
    input  logic [WORD_W-1:0] img_data,
    input  logic              img_last,
    output logic              bus_req,
    output logic              bus_we,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [WORD_W-1:0] bus_rdata,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [2:0]        status_code
);
    localparam int MAXC = (DUMMY_WRITES > POLL_LIMIT) ? DUMMY_WRITES : POLL_LIMIT;
    localparam int CW   = $clog2(MAXC + 1);

    st_e               st_q, st_d;
    code_e             code_q, code_d;
    img_e              ty_q;
    logic              xerr_q, xerr_d;
    logic [WORD_W-1:0] word_q;
    logic              last_q;
    op_t               op;
    logic              ack;
    logic              cnt_load, cnt_dec, cnt_last;
    logic [CW-1:0]     cnt_val;
    logic [SB_TOP:0]   rd;
    logic              unused_rd;

    assign rd        = bus_rdata[SB_TOP:0];
    assign unused_rd = ^bus_rdata[WORD_W-1:SB_TOP+1];

    cfglink_opgen u_opgen (
        .st   (st_q),
        .ty   (ty_q),
        .word (word_q),
        .op   (op)
    );

    assign ack = bus_ack & op.act;

    always_comb begin
        st_d    = st_q;
        code_d  = code_q;
        xerr_d  = xerr_q;
        cnt_dec = 1'b0;
        case (st_q)
            ST_IDLE, ST_FIN: if (start) begin
                st_d   = ST_WEN;
                code_d = CODE_OK;
                xerr_d = 1'b0;
            end
            ST_WEN: if (ack) begin
                if (rd[SB_EN])     st_d = ST_CLK;
                else if (cnt_last) begin st_d = ST_FIN; code_d = CODE_TO_EN; end
                else               cnt_dec = 1'b1;
            end
            ST_CLK:  if (ack) st_d = ST_MODE;
            ST_MODE: if (ack) st_d = ST_CPW1;
            ST_CPW1: if (ack) st_d = ST_DUM1;
            ST_DUM1: if (ack) begin
                if (cnt_last) st_d = ST_CFG;
                else          cnt_dec = 1'b1;
            end
            ST_CFG: if (ack) st_d = ST_WRDY;
            ST_WRDY: if (ack) begin
                if (rd[SB_RDY])    st_d = ST_CPW2;
                else if (cnt_last) begin st_d = ST_FIN; code_d = CODE_TO_RDY; end
                else               cnt_dec = 1'b1;
            end
            ST_CPW2: if (ack) st_d = ST_DUM2;
            ST_DUM2: if (ack) begin
                if (cnt_last) st_d = ST_XST;
                else          cnt_dec = 1'b1;
            end
            ST_XST:  if (ack) st_d = ST_CPWT;
            ST_CPWT: if (ack) st_d = ST_GET;
            ST_GET:  if (img_valid) st_d = ST_WR;
            ST_WR:   if (ack) st_d = ST_CHK;
            ST_CHK: if (ack) begin
                if (rd[SB_ERR]) begin
                    xerr_d = 1'b1;
                    st_d   = ST_TDCPW;
                end else if (last_q) st_d = ST_TDCPW;
                else                 st_d = ST_GET;
            end
            ST_TDCPW: if (ack) st_d = ST_TDDUM;
            ST_TDDUM: if (ack) begin
                if (cnt_last) st_d = ST_TDXS;
                else          cnt_dec = 1'b1;
            end
            ST_TDXS:  if (ack) st_d = ST_TDCFG;
            ST_TDCFG: if (ack) st_d = ST_WNRDY;
            ST_WNRDY: if (ack) begin
                if (!rd[SB_RDY])   st_d = ST_LAT;
                else if (cnt_last) begin st_d = ST_FIN; code_d = CODE_TO_NRDY; end
                else               cnt_dec = 1'b1;
            end
            ST_LAT: if (ack) begin
                if (xerr_q)            code_d = CODE_XFER_ERR;
                else if (rd[SB_LATCH]) code_d = CODE_LATCHED;
                else                   code_d = CODE_OK;
                st_d = ST_CLRM;
            end
            ST_CLRM: if (ack) st_d = ST_WUSR;
            ST_WUSR: if (ack) begin
                if (rd[SB_FCLK] && rd[SB_USER]) st_d = ST_FIN;
                else if (cnt_last) begin st_d = ST_FIN; code_d = CODE_TO_USER; end
                else                            cnt_dec = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign cnt_load = (st_d != st_q) &&
                      (st_d inside {ST_WEN, ST_WRDY, ST_WNRDY, ST_WUSR,
                                    ST_DUM1, ST_DUM2, ST_TDDUM});
    assign cnt_val  = (st_d inside {ST_DUM1, ST_DUM2, ST_TDDUM}) ?
                      CW'(DUMMY_WRITES) : CW'(POLL_LIMIT);

    cfglink_cnt #(.W(CW)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .load (cnt_load),
        .dec  (cnt_dec),
        .val  (cnt_val),
        .last (cnt_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            code_q <= CODE_OK;
            xerr_q <= 1'b0;
            ty_q   <= IMG_PLAIN;
            word_q <= '0;
            last_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            code_q <= code_d;
            xerr_q <= xerr_d;
            if ((st_q == ST_IDLE || st_q == ST_FIN) && start) ty_q <= img_e'(img_type);
            if (st_q == ST_GET && img_valid) begin
                word_q <= img_data;
                last_q <= img_last;
            end
        end
    end

    assign bus_req     = op.act;
    assign bus_we      = op.we;
    assign bus_addr    = ADDR_W'(op.idx);
    assign bus_wdata   = op.data;
    assign img_ready   = (st_q == ST_GET);
    assign done        = (st_q == ST_FIN);
    assign busy        = !(st_q == ST_IDLE || st_q == ST_FIN);
    assign status_code = code_q;
    assign error       = done && (code_q != CODE_OK);
endmodule

// File: rtl/cfglink_seq_chk.sv
module cfglink_seq_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              img_ready,
    input logic              busy,
    input logic              done,
    input logic              error,
    input logic [2:0]        status_code
);
    // R2: a pending request is not withdrawn or altered
    a_r2_req_hold: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> bus_req);
    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> $stable(bus_addr) && $stable(bus_we));
    a_r2_data_stable: assert property (@(posedge clk) disable iff (rst)
        bus_req && !bus_ack |=> $stable(bus_wdata));
    // R7: the stream is accepted only between bus accesses
    a_r7_ready_no_bus: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> !bus_req);
    // R12: an idle sequencer issues nothing
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_req && !img_ready);
    // R12: the result holds while done stays up
    a_r12_result_steady: assert property (@(posedge clk) disable iff (rst)
        done && $past(done) |-> $stable(status_code) && $stable(error));
    // R6: clocks-per-write takes only the legal values
    a_r6_cpw_legal: assert property (@(posedge clk) disable iff (rst)
        bus_req && bus_we && bus_addr == ADDR_W'(1) |->
        bus_wdata[15:8] inside {8'h00, 8'h01, 8'h04, 8'h08});
endmodule

bind cfglink_seq cfglink_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_req     (bus_req),
    .bus_ack     (bus_ack),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .img_ready   (img_ready),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .status_code (status_code)
);

// File: tb/cfglink_seq_bench.sv
`timescale 1ns/1ps
module cfglink_seq_bench;
    localparam int AW = 4;
    localparam int DN = 244;
    localparam int PL = 32;
    localparam int WD = 180000;
    localparam int NL = 4096;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic        start = 1'b0;
    logic [1:0]  img_type = 2'd0;
    logic        img_valid = 1'b0;
    logic        img_ready;
    logic [31:0] img_data = '0;
    logic        img_last = 1'b0;
    logic        bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [31:0] bus_wdata;
    logic        bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        busy, done, error;
    logic [2:0]  status_code;

    cfglink_seq #(.ADDR_W(AW), .DUMMY_WRITES(DN), .POLL_LIMIT(PL)) u_cfglink_seq (
        .clk(clk), .rst(rst), .start(start), .img_type(img_type),
        .img_valid(img_valid), .img_ready(img_ready), .img_data(img_data),
        .img_last(img_last), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .busy(busy), .done(done), .error(error),
        .status_code(status_code)
    );

    int n_cmp = 0, n_bad = 0, cyc = 0;
    always @(posedge clk) cyc++;

    // scenario
    int en_wait, rdy_wait, nrdy_wait, usr_wait, err_at, nwords;
    bit latch_cfg;
    logic [1:0] ty;
    logic [31:0] words [64];

    // register target model
    bit cfg_bit, cfg_was_set, start_bit, mode_bit, mode_cleared;
    int reads_total, cnt_cfg, cnt_mode, xfer_words, ack_wait;
    bit cap_we; logic [AW-1:0] cap_a; logic [31:0] cap_d;
    bit hold_pend, hold_we; logic [AW-1:0] hold_a; logic [31:0] hold_d;
    int viol_r2 = 0, viol_r7 = 0;

    bit lg_we [NL]; logic [AW-1:0] lg_a [NL]; logic [31:0] lg_d [NL]; int nlog;
    bit ex_we [NL]; logic [AW-1:0] ex_a [NL]; logic [31:0] ex_d [NL]; int nex;
    int exp_code, exp_taken;

    function automatic logic [31:0] stat_val();
        logic [31:0] s = '0;
        bit e;
        s[0] = (reads_total >= en_wait);
        if (cfg_bit)          s[1] = (cnt_cfg >= rdy_wait);
        else if (cfg_was_set) s[1] = !(cnt_cfg >= nrdy_wait);
        e = (err_at >= 0) && (xfer_words > err_at);
        s[2] = e;
        s[3] = mode_cleared && (cnt_mode >= usr_wait);
        s[4] = s[3];
        s[5] = e | latch_cfg;
        s[31:6] = $urandom;
        return s;
    endfunction

    always @(negedge clk) begin
        if (hold_pend && (!bus_req || bus_addr != hold_a || bus_we != hold_we || bus_wdata != hold_d))
            viol_r2++;
        if (img_ready && bus_req) viol_r7++;
        if (rst) bus_ack = 1'b0;
        else if (bus_ack) begin
            bus_ack = 1'b0;
            if (cap_we) begin
                if (cap_a == AW'(1)) begin
                    if (mode_bit && !cap_d[0]) begin mode_cleared = 1; cnt_mode = 0; end
                    mode_bit = cap_d[0];
                end else if (cap_a == AW'(2)) begin
                    if (cap_d[0] != cfg_bit) cnt_cfg = 0;
                    if (cap_d[0]) cfg_was_set = 1;
                    cfg_bit = cap_d[0];
                    start_bit = cap_d[1];
                end else if (cap_a == AW'(3)) begin
                    if (start_bit) xfer_words++;
                end
            end
            ack_wait = $urandom % 3;
        end else if (bus_req) begin
            if (ack_wait > 0) ack_wait--;
            else begin
                cap_we = bus_we; cap_a = bus_addr; cap_d = bus_wdata;
                if (!bus_we && bus_addr == AW'(0)) begin
                    bus_rdata = stat_val();
                    reads_total++; cnt_cfg++; cnt_mode++;
                end else bus_rdata = $urandom;
                if (nlog < NL) begin
                    lg_we[nlog] = bus_we; lg_a[nlog] = bus_addr; lg_d[nlog] = bus_wdata;
                end
                nlog++;
                bus_ack = 1'b1;
            end
        end
        hold_pend = bus_req && !bus_ack;
        hold_we = bus_we; hold_a = bus_addr; hold_d = bus_wdata;
    end

    // image source
    bit run = 0, take = 0;
    int idx = 0;
    always @(negedge clk) begin
        if (take) begin idx++; img_valid = 1'b0; take = 0; end
        if (run && !img_valid && idx < nwords && ($urandom % 4 != 0)) begin
            img_valid = 1'b1;
            img_data  = words[idx];
            img_last  = (idx == nwords - 1);
        end
        if (img_valid && img_ready) take = 1;
    end

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
        end
    endtask

    task automatic ex(input bit we, input int a, input logic [31:0] d);
        if (nex < NL) begin ex_we[nex] = we; ex_a[nex] = AW'(a); ex_d[nex] = d; end
        nex++;
    endtask

    task automatic rds(input int n);
        for (int i = 0; i < n; i++) ex(0, 0, 0);
    endtask

    task automatic dums();
        for (int i = 0; i < DN; i++) ex(1, 3, 0);
    endtask

    function automatic logic [7:0] exp_cpw(input logic [1:0] t);
        return (t == 2'd0) ? 8'h01 : (t == 2'd1) ? 8'h04 : 8'h08;
    endfunction

    task automatic build_exp();
        nex = 0; exp_taken = 0;
        if (en_wait >= PL) begin rds(PL); exp_code = 1; return; end
        rds(en_wait + 1);
        ex(1, 1, 32'h2); ex(1, 1, 32'h3); ex(1, 1, 32'h103); dums(); ex(1, 2, 32'h1);
        if (rdy_wait >= PL) begin rds(PL); exp_code = 2; return; end
        rds(rdy_wait + 1);
        ex(1, 1, 32'h103); dums(); ex(1, 2, 32'h3);
        ex(1, 1, {16'h0, exp_cpw(ty), 8'h03});
        for (int i = 0; i < nwords; i++) begin
            ex(1, 3, words[i]); rds(1); exp_taken++;
            if (i == err_at) break;
        end
        ex(1, 1, 32'h103); dums(); ex(1, 2, 32'h1); ex(1, 2, 32'h0);
        if (nrdy_wait >= PL) begin rds(PL); exp_code = 4; return; end
        rds(nrdy_wait + 1);
        rds(1); ex(1, 1, 32'h100);
        if (usr_wait >= PL) begin rds(PL); exp_code = 6; return; end
        rds(usr_wait + 1);
        exp_code = (err_at >= 0) ? 3 : (latch_cfg ? 5 : 0);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    task automatic run_scn(input string tag, input int restart_at);
        int bad_ops, first_bad, t0;
        bad_ops = 0; first_bad = -1;
        run = 0; img_valid = 1'b0; take = 0; idx = 0;
        cfg_bit = 0; cfg_was_set = 0; start_bit = 0; mode_bit = 0; mode_cleared = 0;
        reads_total = 0; cnt_cfg = 0; cnt_mode = 0; xfer_words = 0; nlog = 0;
        for (int i = 0; i < nwords; i++) words[i] = $urandom;
        build_exp();
        img_type = ty; run = 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; img_type = ~ty;
        t0 = cyc;
        while (!done && cyc < WD) begin
            @(negedge clk);
            if (restart_at > 0 && cyc - t0 == restart_at) start = 1'b1;
            else start = 1'b0;
        end
        start = 1'b0;
        if (!done) begin
            chk(0, tag, "watchdog expired", 0, 1);
            finish_run();
        end
        @(negedge clk);
        for (int i = 0; i < nex && i < nlog && i < NL; i++) begin
            if (lg_we[i] != ex_we[i] || lg_a[i] != ex_a[i] || (ex_we[i] && lg_d[i] != ex_d[i])) begin
                bad_ops++;
                if (first_bad < 0) first_bad = i;
            end
        end
        chk(nlog == nex, tag, "access count", nlog, nex);
        if (first_bad >= 0)
            chk(0, tag, "access data at index", int'(lg_d[first_bad]), int'(ex_d[first_bad]));
        else chk(1, tag, "access sequence", 0, 0);
        chk(status_code == 3'(exp_code), tag, "status_code", status_code, exp_code);
        chk(error == (exp_code != 0), "R12", "error flag", error, exp_code != 0);
        chk(done && !busy, "R12", "done/busy", {done, busy}, 2);
        chk(idx == exp_taken, "R7", "words consumed", idx, exp_taken);
        run = 0;
    endtask

    task automatic set_scn(input int e, input int r, input int nr, input int u,
                           input int nw, input int ea, input bit lt, input logic [1:0] t);
        en_wait = e; rdy_wait = r; nrdy_wait = nr; usr_wait = u;
        nwords = nw; err_at = ea; latch_cfg = lt; ty = t;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        nwords = 0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !error && !bus_req && !img_ready, "R1", "idle outputs",
            {busy, done, error, bus_req, img_ready}, 0);
        chk(status_code == 0, "R1", "reset code", status_code, 0);

        set_scn(2, 3, 1, 2, 5, -1, 0, 2'd0); run_scn("R4", 0);
        set_scn(0, 0, 0, 0, 8, -1, 0, 2'd1); run_scn("R6", 0);
        set_scn(1, 1, 2, 1, 3, -1, 0, 2'd2); run_scn("R6", 0);
        set_scn(0, 2, 0, 0, 4, -1, 0, 2'd3); run_scn("R6", 0);
        set_scn(0, 0, 0, 0, 1, -1, 0, 2'd0); run_scn("R7", 0);
        set_scn(1, 1, 1, 1, 6, 2, 0, 2'd0); run_scn("R8", 0);
        set_scn(0, 0, 0, 0, 4, 0, 0, 2'd1); run_scn("R8", 0);
        set_scn(0, 1, 0, 0, 3, -1, 1, 2'd0); run_scn("R10", 0);
        set_scn(PL, 0, 0, 0, 3, -1, 0, 2'd0); run_scn("R3", 0);
        set_scn(PL - 1, 0, 0, 0, 2, -1, 0, 2'd0); run_scn("R3", 0);
        set_scn(0, PL, 0, 0, 3, -1, 0, 2'd0); run_scn("R5", 0);
        set_scn(0, 0, PL, 0, 3, -1, 0, 2'd0); run_scn("R9", 0);
        set_scn(0, 0, 0, PL, 3, -1, 0, 2'd0); run_scn("R11", 0);
        set_scn(0, 0, 0, PL - 1, 3, -1, 0, 2'd0); run_scn("R11", 0);
        set_scn(1, 1, 1, 1, 4, -1, 0, 2'd1); run_scn("R12", 100);
        for (int k = 0; k < 4; k++) begin
            set_scn($urandom % 6, $urandom % 6, $urandom % 6, $urandom % 6,
                    1 + $urandom % 12, -1, 0, 2'($urandom));
            run_scn("R4", 0);
        end

        chk(viol_r2 == 0, "R2", "request held until ack", viol_r2, 0);
        chk(viol_r7 == 0, "R7", "ready during bus access", viol_r7, 0);
        finish_run();
    end

    initial begin
        while (cyc < WD + 1000) @(negedge clk);
        chk(0, "R12", "global watchdog", cyc, WD);
        finish_run();
    end
endmodule